// File: doc/BRIEF.md
# Buck Converter PWM/PFM Mode Controller

This block drives the two gate commands of a synchronous buck power stage. It runs in one of two modes. In clocked peak-current PWM, a periodic clock pulse turns the high-side switch on and a current-loop trip turns it off. In pulse-frequency mode (PFM), a pulse starts only when the output voltage drops below nominal, and a fixed peak-current trip ends it. In both modes, a zero/reverse-current detect ends the low-side conduction so that the output capacitor is not drained back to ground.

Moving between the modes uses hysteresis. In PWM, periods that end with the inductor current reaching zero count as discontinuous conduction (DCM). Once DCM has persisted for `DCM_LIMIT` system clocks, the block drops into PFM. In PFM, a voltage-low request that arrives while a pulse is still ramping down means the load has outgrown the fixed pulse, and the block returns to PWM. Every turn-on of either switch is preceded by a gap of `DEAD_CYC` clocks with both switches off. All inputs are synchronous single-bit comparator results.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset the block is in PWM mode with both switches off. It stays that way until the first PWM clock pulse.
- R2: Encoding: `gate_hi` = 0 means the high-side switch is on and 1 means it is off. `gate_lo` = 1 means the low-side switch is on and 0 means it is off. `pfm_mode` = 1 means PFM and 0 means PWM.
- R3: In PWM, a `pwm_tick` begins a period and switches to the high side.
- R4: In PWM, `cur_trip` during the high-side phase switches to the low side. The low side is held until the next `pwm_tick`.
- R5: In PWM, when `pwm_tick` and `cur_trip` are asserted in the same cycle, the trip wins and the low-side phase is selected.
- R6: In either mode, `zero_det` during the low-side phase turns both switches off. In PWM such a period counts as DCM.
- R7: In PWM, a DCM timer starts at the first zero detect. It is cleared when a period ends without a zero detect. After `DCM_LIMIT` clocks, the block enters PFM, and it does so only while both switches are off.
- R8: In PFM, `vout_low` while both switches are off starts a pulse on the high side. `pwm_tick` and `cur_trip` have no effect.
- R9: In PFM, `pk_trip` during the high-side phase switches to the low side.
- R10: In PFM, `vout_low` during the low-side phase with no zero detect in that cycle returns the block to PWM mode.
- R11: The two switches are never on together. Every turn-on follows at least `DEAD_CYC` cycles with both off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | PWM period clock pulse |
| cur_trip | input | 1 | Current loop trip (PWM turn-off) |
| pk_trip | input | 1 | Fixed peak-current trip (PFM turn-off) |
| zero_det | input | 1 | Inductor current reached zero or reversed |
| vout_low | input | 1 | Output voltage below nominal |
| gate_hi | output | 1 | High-side gate command, 0 = on |
| gate_lo | output | 1 | Low-side gate command, 1 = on |
| pfm_mode | output | 1 | 1 while in PFM |

## Verification
The assertions assume that every input is already synchronous to `clk` and that `DEAD_CYC` is at least one. They also assume that a mode change is caused only by the port events named in R7 and R10. The directed stimulus changes inputs only on falling clock edges and holds trips for one cycle. It includes the coincident tick-and-trip case and a voltage-low request during a PFM ramp-down. A final phase drives sparse random pulses on all five inputs, still on falling edges, so the inputs always stay in the synchronous form that the checks rely on.

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl #(
  parameter int unsigned DEAD_CYC  = 4,
  parameter int unsigned DCM_LIMIT = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_tick,
  input  logic cur_trip,
  input  logic pk_trip,
  input  logic zero_det,
  input  logic vout_low,
  output logic gate_hi,
  output logic gate_lo,
  output logic pfm_mode
);
  localparam int DTW = $clog2(DEAD_CYC + 1);
  localparam int CW  = $clog2(DCM_LIMIT + 1);
  localparam logic [DTW-1:0] DT_LOAD = DTW'(DEAD_CYC - 1);
  localparam logic [CW-1:0]  CNT_TOP = CW'(DCM_LIMIT);

  typedef enum logic [1:0] {SW_OFF, SW_HI, SW_LO} sw_t;

  sw_t           ph, sw;
  logic [DTW-1:0] dt;
  logic [CW-1:0]  cnt;
  logic           run, per_dcm, pfm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= SW_OFF;
      sw      <= SW_OFF;
      dt      <= DT_LOAD;
      cnt     <= '0;
      run     <= 1'b0;
      per_dcm <= 1'b0;
      pfm     <= 1'b0;
    end else begin
      if (ph != sw && sw != SW_OFF) begin
        sw <= SW_OFF;
        dt <= DT_LOAD;
      end else if (dt != '0) begin
        dt <= dt - 1'b1;
      end else if (ph != sw) begin
        sw <= ph;
      end

      if (!pfm) begin
        if (run && cnt != CNT_TOP) cnt <= cnt + 1'b1;
        if (cur_trip && (ph == SW_HI || pwm_tick)) ph <= SW_LO;
        else if (pwm_tick) ph <= SW_HI;
        else if (ph == SW_LO && zero_det) begin
          ph      <= SW_OFF;
          per_dcm <= 1'b1;
          run     <= 1'b1;
        end
        if (pwm_tick) begin
          per_dcm <= 1'b0;
          if (!per_dcm) begin
            cnt <= '0;
            run <= 1'b0;
          end
        end else if (cnt == CNT_TOP && ph == SW_OFF) begin
          pfm     <= 1'b1;
          cnt     <= '0;
          run     <= 1'b0;
          per_dcm <= 1'b0;
        end
      end else begin
        if (ph == SW_OFF && vout_low) ph <= SW_HI;
        else if (ph == SW_HI && pk_trip) ph <= SW_LO;
        else if (ph == SW_LO && zero_det) ph <= SW_OFF;
        else if (ph == SW_LO && vout_low) pfm <= 1'b0;
      end
    end
  end

  assign gate_hi  = (sw != SW_HI);
  assign gate_lo  = (sw == SW_LO);
  assign pfm_mode = pfm;

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!gate_hi && gate_lo));

  assert_gap_before_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_hi) || $rose(gate_lo)) |-> ($past(gate_hi) && !$past(gate_lo)));

  assert_trip_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfm && cur_trip && pwm_tick) |=> (ph == SW_LO));

  assert_pfm_entry_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_mode) |-> (gate_hi && !gate_lo));

  assert_pfm_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pfm && ph == SW_OFF && !vout_low) |=> (ph == SW_OFF && pfm_mode));

  assert_pfm_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pfm_mode) |-> $past(vout_low));
endmodule

// File: tb/buck_mode_ctrl_tb.sv
module buck_mode_ctrl_tb_top;
  localparam int DEAD = 3;
  localparam int LIM  = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_tick = 0, cur_trip = 0, pk_trip = 0, zero_det = 0, vout_low = 0;
  logic gate_hi, gate_lo, pfm_mode;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  always #4 clk = ~clk;

  buck_mode_ctrl #(.DEAD_CYC(DEAD), .DCM_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .cur_trip(cur_trip),
    .pk_trip(pk_trip), .zero_det(zero_det), .vout_low(vout_low),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .pfm_mode(pfm_mode));

  // reference model: m_sw/m_ph 0 = off, 1 = high side, 2 = low side
  int m_mode, m_ph, m_sw, m_age, m_run, m_cnt, m_per, nph, c0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ph = 0; m_sw = 0; m_age = 0;
      m_run = 0; m_cnt = 0; m_per = 0;
    end else begin
      if (m_sw != 0 && m_sw != m_ph) begin m_sw = 0; m_age = 0; end
      else if (m_sw == 0 && m_ph != 0 && m_age >= DEAD - 1) m_sw = m_ph;
      else if (m_age < 100000) m_age++;
      nph = m_ph;
      c0 = m_cnt;
      if (m_mode == 0) begin
        if (m_run != 0 && m_cnt < LIM) m_cnt++;
        if (cur_trip && (m_ph == 1 || pwm_tick)) nph = 2;
        else if (pwm_tick) nph = 1;
        else if (m_ph == 2 && zero_det) begin nph = 0; m_per = 1; m_run = 1; end
        if (pwm_tick) begin
          if (m_per == 0) begin m_cnt = 0; m_run = 0; end
          m_per = 0;
        end else if (c0 == LIM && m_ph == 0) begin
          m_mode = 1; m_cnt = 0; m_run = 0; m_per = 0;
        end
      end else begin
        case (m_ph)
          0: if (vout_low) nph = 1;
          1: if (pk_trip) nph = 2;
          default: if (zero_det) nph = 0; else if (vout_low) m_mode = 0;
        endcase
      end
      m_ph = nph;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  int off_run = 100;
  logic prev_hi = 1, prev_lo = 0;
  always @(negedge clk) begin
    if (started) begin
      chk(gate_hi == (m_sw != 1), "R2 gate_hi vs model", gate_hi, m_sw != 1);
      chk(gate_lo == (m_sw == 2), "R2 gate_lo vs model", gate_lo, m_sw == 2);
      chk(pfm_mode == m_mode[0], "R7 R10 mode vs model", pfm_mode, m_mode);
      if (!gate_hi && gate_lo) chk(0, "R11 overlap", 1, 0);
      if ((!gate_hi && prev_hi) || (gate_lo && !prev_lo))
        chk(prev_hi && !prev_lo && off_run >= DEAD, "R11 dead gap", off_run, DEAD);
      if (gate_hi && !gate_lo) off_run++; else off_run = 0;
      prev_hi = gate_hi; prev_lo = gate_lo;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: pwm_tick = 1; 1: cur_trip = 1; 2: pk_trip = 1; 3: zero_det = 1;
      4: vout_low = 1; default: begin pwm_tick = 1; cur_trip = 1; end
    endcase
    @(negedge clk);
    pwm_tick = 0; cur_trip = 0; pk_trip = 0; zero_det = 0; vout_low = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    started = 1;
    chk(gate_hi && !gate_lo && !pfm_mode, "R1 reset state", {gate_hi, gate_lo, pfm_mode}, 3'b100);
    cyc(12);
    chk(gate_hi && !gate_lo, "R1 idle before first tick", {gate_hi, gate_lo}, 2'b10);

    pulse(0); cyc(DEAD + 3);
    chk(!gate_hi && !gate_lo, "R3 high side on", {gate_hi, gate_lo}, 2'b00);
    cyc(5); pulse(1); cyc(DEAD + 3);
    chk(gate_hi && gate_lo, "R4 low side after trip", {gate_hi, gate_lo}, 2'b11);
    cyc(20);
    chk(gate_hi && gate_lo, "R4 low side held", {gate_hi, gate_lo}, 2'b11);
    pulse(5); cyc(DEAD + 3);
    chk(gate_hi && gate_lo, "R5 trip beats tick", {gate_hi, gate_lo}, 2'b11);

    for (int i = 0; i < 4; i++) begin
      pulse(0); cyc(10); pulse(1); cyc(30);
    end
    chk(!pfm_mode, "R7 continuous periods stay PWM", pfm_mode, 0);

    for (int i = 0; i < 12 && !pfm_mode; i++) begin
      pulse(0); cyc(10); pulse(1); cyc(8); pulse(3); cyc(DEAD + 1);
      chk(gate_hi && !gate_lo, "R6 zero detect turns both off", {gate_hi, gate_lo}, 2'b10);
      if (i == 0) begin pulse(0); cyc(10); pulse(1); cyc(30); end
      cyc(14);
    end
    chk(pfm_mode, "R7 entered PFM after DCM", pfm_mode, 1);
    chk(gate_hi && !gate_lo, "R7 off at PFM entry", {gate_hi, gate_lo}, 2'b10);

    pulse(0); cyc(2); pulse(1); cyc(DEAD + 3);
    chk(gate_hi && !gate_lo && pfm_mode, "R8 tick and trip ignored in PFM", {gate_hi, gate_lo}, 2'b10);
    pulse(4); cyc(DEAD + 3);
    chk(!gate_hi && !gate_lo, "R8 PFM pulse on vout_low", {gate_hi, gate_lo}, 2'b00);
    pulse(2); cyc(DEAD + 3);
    chk(gate_hi && gate_lo, "R9 peak trip to low side", {gate_hi, gate_lo}, 2'b11);
    pulse(3); cyc(DEAD + 3);
    chk(gate_hi && !gate_lo && pfm_mode, "R6 PFM zero detect", {gate_hi, gate_lo}, 2'b10);

    pulse(4); cyc(6); pulse(2); cyc(DEAD + 3); pulse(4); cyc(2);
    chk(!pfm_mode, "R10 back to PWM on early vout_low", pfm_mode, 0);
    pulse(3); cyc(DEAD + 3); pulse(5); cyc(DEAD + 3);
    chk(gate_hi && gate_lo, "R5 trip beats tick from idle", {gate_hi, gate_lo}, 2'b11);

    for (int i = 0; i < 5000; i++) begin
      pwm_tick = ($urandom_range(29) == 0);
      cur_trip = ($urandom_range(9) == 0);
      pk_trip  = ($urandom_range(9) == 0);
      zero_det = ($urandom_range(11) == 0);
      vout_low = ($urandom_range(19) == 0);
      @(negedge clk);
    end
    pwm_tick = 0; cur_trip = 0; pk_trip = 0; zero_det = 0; vout_low = 0;
    cyc(5);
    summary();
  end
endmodule